// File: doc/BRIEF.md
# Extended Mode Register Programming Sequencer

This block sits on the controller side of a mobile SDR SDRAM. It issues one extended-mode-register write command, which selects how much of the array keeps refreshing in self-refresh and how strongly the output drivers drive. A client pulses `req` with a 3-bit coverage code and a 2-bit drive code. The sequencer captures both codes and waits until the memory reports every bank precharged and clock enable high. It then drives the command for one cycle and holds the command bus at no-operation through the settle gap. At the end it pulses `done`.

The command word has a fixed layout. The bank-select bits read `2'b10` so that the extended register is written rather than the base mode register. Address bits [2:0] carry the coverage code. Address bits [6:5] carry the drive code, or stay low when the drive-strength field is disabled by the `DRIVE_FIELD` parameter. Every other address bit is held at zero. If no command is ever issued, the memory keeps its own defaults: full-array coverage, and a drive strength that depends on the supply.

States: `ST_IDLE` (NOP, ready for a request), `ST_WAIT` (request held until the banks are idle and clock enable is high), `ST_ISSUE` (command on the pins), `ST_GAP` (settle cycles) and `ST_DONE` (completion pulse). Transitions:
- `ST_IDLE`→`ST_ISSUE` on a request when the memory is ready.
- `ST_IDLE`→`ST_WAIT` on a request when it is not.
- `ST_WAIT`→`ST_ISSUE` once ready.
- `ST_ISSUE`→`ST_GAP` always.
- `ST_GAP`→`ST_DONE` after `GAP_CYC` cycles.
- `ST_DONE`→`ST_IDLE` always.

Top module: `emrs_seq`

## Requirements
- R1: Outside the command cycle, `cs_n`, `ras_n`, `cas_n` and `we_n` are all 1, and `ba` and `addr` are all zero.
- R2: The command is `cs_n`, `ras_n`, `cas_n` and `we_n` all 0 together. It lasts exactly one cycle for each accepted request.
- R3: During the command cycle, `ba` equals `2'b10` (bit 1 high, bit 0 low).
- R4: During the command cycle, `addr[2:0]` equals the coverage code and `addr[6:5]` equals the drive code. All other address bits are 0.
- R5: With `DRIVE_FIELD`=0, `addr[6:5]` is 0 in the command cycle whatever drive code was requested.
- R6: The command is never driven unless `banks_idle` and `cke_high` were both 1 on the previous edge. A request made while they are not both 1 is held, with `busy`=1 and the bus at NOP, and is issued in the cycle after both become 1.
- R7: After the command, `GAP_CYC` NOP cycles follow with `done`=0. Then `done` is 1 for exactly one cycle, and `busy` drops in the cycle after that.
- R8: A request made while `busy`=1 is ignored: no extra command is produced.
- R9: During and right after reset, `busy`=0, `done`=0 and the bus is at NOP.
- R10: The codes are captured on the cycle the request is accepted. Later changes on the code inputs do not affect the command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request to program the extended register |
| pasr_code | input | 3 | Self-refresh coverage code |
| drive_code | input | 2 | Output drive-strength code |
| banks_idle | input | 1 | All banks precharged |
| cke_high | input | 1 | Clock enable is already high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bus |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds two copies that share one set of inputs. `u0` uses the defaults (`ADDR_W`=13, `GAP_CYC`=2, `DRIVE_FIELD`=1). `u1` has `DRIVE_FIELD`=0. This small configuration lets the bench sweep all 32 coverage/drive combinations through both copies. Each combination gets the full cycle-by-cycle check of command, gap and done. The second copy reaches the disabled-field variant on the same stimulus. Separate runs hold off the banks-idle and clock-enable conditions, scramble the codes after acceptance, and raise requests during the gap.

// File: rtl/emrs_pkg.sv
package emrs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ISSUE,
        ST_GAP,
        ST_DONE
    } emrs_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_NOP  = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t PINS_EMRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
    localparam logic [1:0] BA_EXT   = 2'b10;

    localparam int PASR_W   = 3;
    localparam int DRIVE_W  = 2;
    localparam int PASR_LSB = 0;
    localparam int DRIVE_LSB = 5;
endpackage

// File: rtl/emrs_word.sv
module emrs_word
    import emrs_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter bit DRIVE_FIELD = 1'b1
) (
    input  logic [PASR_W-1:0]  pasr,
    input  logic [DRIVE_W-1:0] drive,
    output logic [ADDR_W-1:0]  word
);
    logic [ADDR_W-1:0] pasr_part;
    logic [ADDR_W-1:0] drive_part;

    always_comb begin
        pasr_part = '0;
        pasr_part[PASR_LSB +: PASR_W] = pasr;
    end

    generate
        if (DRIVE_FIELD) begin : g_drive
            always_comb begin
                drive_part = '0;
                drive_part[DRIVE_LSB +: DRIVE_W] = drive;
            end
        end else begin : g_no_drive
            assign drive_part = '0;
        end
    endgenerate

    assign word = pasr_part | drive_part;
endmodule

// File: rtl/emrs_gap_timer.sv
module emrs_gap_timer #(
    parameter int GAP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);
    localparam int CNT_W = $clog2(GAP_CYC + 1) + 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(GAP_CYC);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/emrs_seq.sv
module emrs_seq
    import emrs_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int GAP_CYC     = 2,
    parameter bit DRIVE_FIELD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [2:0]        pasr_code,
    input  logic [1:0]        drive_code,
    input  logic              banks_idle,
    input  logic              cke_high,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              busy,
    output logic              done
);
    emrs_state_t state, state_nx;
    logic [PASR_W-1:0]  pasr_q;
    logic [DRIVE_W-1:0] drive_q;
    logic [ADDR_W-1:0]  word;
    logic               ready;
    logic               accept;
    logic               gap_last;
    cmd_pins_t          pins;

    assign ready  = banks_idle && cke_high;
    assign accept = (state == ST_IDLE) && req;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pasr_q  <= '0;
            drive_q <= '0;
        end else if (accept) begin
            pasr_q  <= pasr_code;
            drive_q <= drive_code;
        end
    end

    emrs_word #(
        .ADDR_W      (ADDR_W),
        .DRIVE_FIELD (DRIVE_FIELD)
    ) u_word (
        .pasr  (pasr_q),
        .drive (drive_q),
        .word  (word)
    );

    emrs_gap_timer #(
        .GAP_CYC (GAP_CYC)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state == ST_ISSUE),
        .last  (gap_last)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req) state_nx = ready ? ST_ISSUE : ST_WAIT;
            ST_WAIT:  if (ready) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_GAP;
            ST_GAP:   if (gap_last) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        pins = PINS_NOP;
        ba   = '0;
        addr = '0;
        busy = 1'b1;
        done = 1'b0;
        unique case (state)
            ST_IDLE:  busy = 1'b0;
            ST_WAIT:  ;
            ST_ISSUE: begin
                pins = PINS_EMRS;
                ba   = BA_EXT;
                addr = word;
            end
            ST_GAP:   ;
            ST_DONE:  done = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    assign cs_n  = pins.cs_n;
    assign ras_n = pins.ras_n;
    assign cas_n = pins.cas_n;
    assign we_n  = pins.we_n;
endmodule

// File: rtl/emrs_seq_chk.sv
module emrs_seq_chk #(
    parameter int ADDR_W      = 13,
    parameter int GAP_CYC     = 2,
    parameter bit DRIVE_FIELD = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              banks_idle,
    input logic              cke_high,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [1:0]        ba,
    input logic [ADDR_W-1:0] addr,
    input logic              done
);
    localparam int SC_W = $clog2(GAP_CYC + 3) + 1;
    localparam logic [ADDR_W-1:0] USED = ADDR_W'(7'b110_0111);

    logic [SC_W-1:0] since_cmd;
    logic            ready_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cmd <= '0;
            ready_q   <= 1'b0;
        end else begin
            ready_q <= banks_idle && cke_high;
            if (!cs_n) since_cmd <= SC_W'(1);
            else if (since_cmd != '0 && since_cmd != '1) since_cmd <= since_cmd + 1'b1;
        end
    end

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (ras_n && cas_n && we_n && ba == 2'b00 && addr == '0)); // R1
    AST_CMD_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (!ras_n && !cas_n && !we_n)); // R2
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> cs_n); // R2
    AST_CMD_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> ba == 2'b10); // R3
    AST_UNUSED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> (addr & ~USED) == '0); // R4
    AST_CMD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> ready_q); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> since_cmd == SC_W'(GAP_CYC + 1)); // R7

    generate
        if (!DRIVE_FIELD) begin : g_no_drive
            AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
                !cs_n |-> addr[6:5] == 2'b00); // R5
        end
    endgenerate
endmodule

bind emrs_seq emrs_seq_chk #(
    .ADDR_W      (ADDR_W),
    .GAP_CYC     (GAP_CYC),
    .DRIVE_FIELD (DRIVE_FIELD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .banks_idle (banks_idle),
    .cke_high   (cke_high),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .ba         (ba),
    .addr       (addr),
    .done       (done)
);

// File: tb/sim_emrs_seq.sv
module sim_emrs_seq;
    localparam int AW  = 13;
    localparam int GAP = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [2:0] pasr = '0;
    logic [1:0] drv = '0;
    logic banks_idle = 1'b1;
    logic cke_high = 1'b1;

    logic cs0, ras0, cas0, we0, busy0, done0;
    logic [1:0] ba0;
    logic [AW-1:0] addr0;
    logic cs1, ras1, cas1, we1, busy1, done1;
    logic [1:0] ba1;
    logic [AW-1:0] addr1;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    emrs_seq #(.ADDR_W(AW), .GAP_CYC(GAP), .DRIVE_FIELD(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .pasr_code(pasr), .drive_code(drv),
        .banks_idle(banks_idle), .cke_high(cke_high),
        .cs_n(cs0), .ras_n(ras0), .cas_n(cas0), .we_n(we0), .ba(ba0), .addr(addr0),
        .busy(busy0), .done(done0));

    emrs_seq #(.ADDR_W(AW), .GAP_CYC(GAP), .DRIVE_FIELD(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .req(req), .pasr_code(pasr), .drive_code(drv),
        .banks_idle(banks_idle), .cke_high(cke_high),
        .cs_n(cs1), .ras_n(ras1), .cas_n(cas1), .we_n(we1), .ba(ba1), .addr(addr1),
        .busy(busy1), .done(done1));

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [4:0] pins0();
        return {cs0, ras0, cas0, we0, busy0};
    endfunction

    task automatic chk_nop(input string tag, input logic exp_busy);
        logic [31:0] a0, a1, e;
        a0 = {cs0, ras0, cas0, we0, ba0, addr0};
        a1 = {cs1, ras1, cas1, we1, ba1, addr1};
        e  = {4'b1111, 2'b00, {AW{1'b0}}};
        chk(a0 == e, {tag, " u0 NOP"}, a0, e);
        chk(a1 == e, {tag, " u1 NOP"}, a1, e);
        chk(busy0 == exp_busy && busy1 == exp_busy, {tag, " busy"}, {busy0, busy1}, {exp_busy, exp_busy});
    endtask

    // Checks the command cycle and everything up to idle; call at the negedge of the command cycle.
    task automatic chk_cmd(input logic [2:0] p, input logic [1:0] d, input logic poke);
        logic [AW-1:0] e0, e1;
        e0 = AW'(p) | (AW'(d) << 5);
        e1 = AW'(p);
        chk({cs0, ras0, cas0, we0} == 4'b0000, "R2 u0 command pins", {cs0, ras0, cas0, we0}, 0);
        chk({cs1, ras1, cas1, we1} == 4'b0000, "R2 u1 command pins", {cs1, ras1, cas1, we1}, 0);
        chk(ba0 == 2'b10 && ba1 == 2'b10, "R3 bank select", {ba0, ba1}, 4'b1010);
        chk(addr0 == e0, "R4 address word", addr0, e0);
        chk(addr1 == e1, "R5 drive field disabled", addr1, e1);
        if (poke) req = 1'b1;
        for (int g = 0; g < GAP; g++) begin
            @(negedge clk);
            chk_nop("R7 gap", 1'b1);
            chk(!done0 && !done1, "R7 done low in gap", {done0, done1}, 0);
        end
        @(negedge clk);
        chk_nop("R7 done cycle", 1'b1);
        chk(done0 && done1, "R7 done pulse", {done0, done1}, 2'b11);
        req = 1'b0;
        @(negedge clk);
        chk(!done0 && !done1, "R7 done single", {done0, done1}, 0);
        chk_nop("R8 idle after", 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        req = 1'b1;
        chk_nop("R9 in reset", 1'b0);
        chk(!done0 && !done1, "R9 done in reset", {done0, done1}, 0);
        rst_n = 1'b1;
        req = 1'b0;
        @(negedge clk);
        chk_nop("R9 after reset", 1'b0);

        // Sweep of all codes; R10 scramble after acceptance, R8 request during gap.
        for (int c = 0; c < 32; c++) begin
            pasr = 3'(c);
            drv  = 2'(c >> 3);
            req  = 1'b1;
            @(negedge clk);
            req  = 1'b0;
            pasr = ~pasr;
            drv  = ~drv;
            chk_cmd(3'(c), 2'(c >> 3), c[0]);
        end

        // R6: banks not idle holds the request
        banks_idle = 1'b0;
        pasr = 3'd5; drv = 2'd2; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk_nop("R6 hold banks", 1'b1);
            @(negedge clk);
        end
        banks_idle = 1'b1;
        cke_high = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk_nop("R6 hold cke", 1'b1);
        end
        cke_high = 1'b1;
        @(negedge clk);
        chk_cmd(3'd5, 2'd2, 1'b0);

        // R6: request with cke low at request time
        cke_high = 1'b0;
        pasr = 3'd3; drv = 2'd1; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk_nop("R6 cke low at request", 1'b1);
        cke_high = 1'b1;
        @(negedge clk);
        chk_cmd(3'd3, 2'd1, 1'b0);

        repeat (3) begin
            @(negedge clk);
            chk_nop("R1 quiet idle", 1'b0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule